// File: doc/BRIEF.md
# Modular adder-subtractor

This block adds or subtracts two residues and returns the result reduced into the range 0 to M-1 for a modulus M that is fixed when the block is built. Both operands are K-bit values that the surrounding logic has already brought below M. One control input picks the operation. The result stays a proper residue: a sum that reaches M is brought back down, and a difference that would go negative folds back up into the range.

The unit is purely combinational. It holds no state, so the output follows the inputs after one settle time. The width K and the modulus M come from a shared parameter package, and an instance may override them. When M equals 2^K, a cheaper variant that only wraps is built in place of the correcting one. Out-of-range parameters stop elaboration. The result for an operand of M or above is not defined.

Top module: `modas_unit`

## Requirements
- R1: With `op_sub` = 0 and x + y < M, `res_o` equals x + y.
- R2: With `op_sub` = 0 and x + y >= M, `res_o` equals x + y - M.
- R3: With `op_sub` = 1 and x >= y, `res_o` equals x - y.
- R4: With `op_sub` = 1 and x < y, `res_o` equals x - y + M.
- R5: For every pair of operands below M, under either operation, `res_o` is below M.
- R6: The output depends only on the present inputs. The same operands and `op_sub` value give the same result whatever the earlier inputs were, and a change of `op_sub` alone switches between sum and difference within the settle time.
- R7: When M = 2^K, `res_o` is x + y (for `op_sub` = 0) or x - y (for `op_sub` = 1), truncated to K bits.
- R8: At the extremes of the range: (M-1) + (M-1) gives M-2, (M-1) + 1 gives 0, 0 - (M-1) gives 1, and 0 - 1 gives M-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH | First operand, a residue below MODULUS |
| y_i | input | WIDTH | Second operand, a residue below MODULUS |
| op_sub | input | 1 | Operation select: 0 adds, 1 subtracts y from x |
| res_o | output | WIDTH | Result reduced modulo MODULUS |

## Verification
Immediate assertions in the add and subtract paths re-check the result whenever the inputs are in range. They confirm that the output is below M, and that adding back M or y gives the raw sum or the minuend. This covers the wrap and fold cases on every input change. They also confirm that the discarded upper bits of each corrected candidate are zero. The assertions cannot show that the select picks the correct path, that the output holds no memory of earlier inputs, or that the power-of-two variant and the range extremes give the exact values. For those, the bench sweeps every operand pair under both operations on the default modulus and on a 2^K modulus, and compares the output against an integer reference.

// File: rtl/modas_pkg.sv
`timescale 1ns/1ps
package modas_pkg;

   // shared parameter set for all modular add/sub instances
   localparam int unsigned MODAS_WIDTH   = 8;
   localparam int unsigned MODAS_MODULUS = 251;

   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } modas_op_e;

   // true when the modulus is exactly 2^width, so plain wrap is enough
   function automatic bit modulus_is_full(input int unsigned w, input int unsigned m);
      return (64'(m) == (64'd1 << w));
   endfunction

   // true when the parameter pair is legal
   function automatic bit params_legal(input int unsigned w, input int unsigned m);
      return (w >= 1) && (w <= 30) && (m >= 2) && (64'(m) <= (64'd1 << w));
   endfunction

endpackage

// File: rtl/modas_add_path.sv
`timescale 1ns/1ps
module modas_add_path #(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned MODULUS = 251
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] sum_o
);
   localparam int unsigned      EW    = WIDTH + 2;
   localparam logic [EW-1:0]    MOD_E = EW'(MODULUS);
   localparam bit               FULL  = modas_pkg::modulus_is_full(WIDTH, MODULUS);

   logic [EW-1:0] raw_e;
   logic          in_rng;

   assign raw_e  = EW'(a_i) + EW'(b_i);
   assign in_rng = (EW'(a_i) < MOD_E) && (EW'(b_i) < MOD_E);

   generate
      if (FULL) begin : g_wrap
         assign sum_o = raw_e[WIDTH-1:0];
      end else begin : g_fold
         logic [EW-1:0] trial;
         assign trial = raw_e - MOD_E;
         // sign of the trial correction picks the candidate
         assign sum_o = trial[EW-1] ? raw_e[WIDTH-1:0] : trial[WIDTH-1:0];

         always_comb begin
            if (in_rng && !trial[EW-1]) begin
               p_trial_fit_r2: assert (trial[EW-2:WIDTH] == '0)
                  else $error("corrected sum does not fit in WIDTH bits");
            end
         end
      end
   endgenerate

   always_comb begin
      if (in_rng) begin
         p_add_range_r5: assert (EW'(sum_o) < MOD_E)
            else $error("sum not below modulus");
         if (raw_e >= MOD_E) begin
            p_add_wrap_r2: assert (EW'(sum_o) + MOD_E == raw_e)
               else $error("wrapped sum wrong");
         end else begin
            p_add_plain_r1: assert (EW'(sum_o) == raw_e)
               else $error("plain sum wrong");
         end
      end
   end
endmodule

// File: rtl/modas_sub_path.sv
`timescale 1ns/1ps
module modas_sub_path #(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned MODULUS = 251
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] diff_o
);
   localparam int unsigned      EW    = WIDTH + 2;
   localparam logic [EW-1:0]    MOD_E = EW'(MODULUS);
   localparam bit               FULL  = modas_pkg::modulus_is_full(WIDTH, MODULUS);

   logic [EW-1:0] diff_e;
   logic          borrow;
   logic          in_rng;

   assign diff_e = EW'(a_i) - EW'(b_i);
   assign borrow = diff_e[EW-1];
   assign in_rng = (EW'(a_i) < MOD_E) && (EW'(b_i) < MOD_E);

   generate
      if (FULL) begin : g_wrap
         assign diff_o = diff_e[WIDTH-1:0];
      end else begin : g_fold
         logic [EW-1:0] fold;
         assign fold   = diff_e + MOD_E;
         // a borrow out of the raw difference selects the folded candidate
         assign diff_o = borrow ? fold[WIDTH-1:0] : diff_e[WIDTH-1:0];

         always_comb begin
            if (in_rng && borrow) begin
               p_fold_fit_r4: assert (fold[EW-1:WIDTH] == '0)
                  else $error("folded difference does not fit in WIDTH bits");
            end
         end
      end
   endgenerate

   always_comb begin
      if (in_rng) begin
         p_sub_range_r5: assert (EW'(diff_o) < MOD_E)
            else $error("difference not below modulus");
         if (EW'(a_i) >= EW'(b_i)) begin
            p_sub_plain_r3: assert (EW'(diff_o) + EW'(b_i) == EW'(a_i))
               else $error("plain difference wrong");
         end else begin
            p_sub_fold_r4: assert (EW'(diff_o) + EW'(b_i) == EW'(a_i) + MOD_E)
               else $error("folded difference wrong");
         end
      end
   end
endmodule

// File: rtl/modas_select.sv
`timescale 1ns/1ps
module modas_select #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] add_i,
   input  logic [WIDTH-1:0] sub_i,
   input  logic             op_i,
   output logic [WIDTH-1:0] res_o
);
   import modas_pkg::*;

   modas_op_e op;
   assign op = modas_op_e'(op_i);

   always_comb begin
      unique case (op)
         OP_SUB:  res_o = sub_i;
         default: res_o = add_i;
      endcase
   end
endmodule

// File: rtl/modas_unit.sv
`timescale 1ns/1ps
module modas_unit #(
   parameter int unsigned WIDTH   = modas_pkg::MODAS_WIDTH,
   parameter int unsigned MODULUS = modas_pkg::MODAS_MODULUS
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             op_sub,
   output logic [WIDTH-1:0] res_o
);
   localparam int unsigned   EW    = WIDTH + 2;
   localparam logic [EW-1:0] MOD_E = EW'(MODULUS);

   generate
      if (!modas_pkg::params_legal(WIDTH, MODULUS)) begin : g_bad_params
         $error("modas_unit: need 1 <= WIDTH <= 30 and 2 <= MODULUS <= 2**WIDTH");
      end
   endgenerate

   logic [WIDTH-1:0] sum_w;
   logic [WIDTH-1:0] diff_w;

   modas_add_path #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_add (
      .a_i   (x_i),
      .b_i   (y_i),
      .sum_o (sum_w)
   );

   modas_sub_path #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_sub (
      .a_i    (x_i),
      .b_i    (y_i),
      .diff_o (diff_w)
   );

   modas_select #(.WIDTH(WIDTH)) u_sel (
      .add_i (sum_w),
      .sub_i (diff_w),
      .op_i  (op_sub),
      .res_o (res_o)
   );

   always_comb begin
      if ((EW'(x_i) < MOD_E) && (EW'(y_i) < MOD_E)) begin
         p_out_range_r5: assert (EW'(res_o) < MOD_E)
            else $error("result not below modulus");
      end
   end
endmodule

// File: tb/modas_unit_tb.sv
`timescale 1ns/1ps
module modas_unit_tb;
   import modas_pkg::*;

   localparam int W  = MODAS_WIDTH;
   localparam int M  = MODAS_MODULUS;
   localparam int W2 = 4;
   localparam int M2 = 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [W-1:0]  x, y, z;
   logic          op;
   logic [W2-1:0] x2, y2, z2;
   logic          op2;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   modas_unit u_dut (.x_i(x), .y_i(y), .op_sub(op), .res_o(z));
   modas_unit #(.WIDTH(W2), .MODULUS(M2)) u_dut_pow2 (.x_i(x2), .y_i(y2), .op_sub(op2), .res_o(z2));

   function automatic int ref_mod(int a, int b, bit sub, int m);
      int r;
      r = sub ? (a - b) : (a + b);
      return ((r % m) + m) % m;
   endfunction

   task automatic check(string req, int act, int exp, int a, int b, bit sub);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: x=%0d y=%0d op_sub=%0d actual=%0d expected=%0d", req, a, b, sub, act, exp);
      end
   endtask

   task automatic apply(int a, int b, bit sub);
      @(posedge clk);
      x  = W'(a);
      y  = W'(b);
      op = sub;
      @(negedge clk);
   endtask

   task automatic apply2(int a, int b, bit sub);
      @(posedge clk);
      x2  = W2'(a);
      y2  = W2'(b);
      op2 = sub;
      @(negedge clk);
   endtask

   // idle inputs all zero: both operations give 0 (R1, R3)
   task automatic t_idle_zero();
      apply(0, 0, 1'b0);
      check("R1", int'(z), 0, 0, 0, 1'b0);
      apply(0, 0, 1'b1);
      check("R3", int'(z), 0, 0, 0, 1'b1);
   endtask

   task automatic t_add_sweep();
      for (int i = 0; i < M; i++) begin
         for (int j = 0; j < M; j++) begin
            apply(i, j, 1'b0);
            check((i + j < M) ? "R1" : "R2", int'(z), ref_mod(i, j, 1'b0, M), i, j, 1'b0);
            if (int'(z) >= M) check("R5", int'(z), M - 1, i, j, 1'b0);
         end
      end
   endtask

   task automatic t_sub_sweep();
      for (int i = 0; i < M; i++) begin
         for (int j = 0; j < M; j++) begin
            apply(i, j, 1'b1);
            check((i >= j) ? "R3" : "R4", int'(z), ref_mod(i, j, 1'b1, M), i, j, 1'b1);
            if (int'(z) >= M) check("R5", int'(z), M - 1, i, j, 1'b1);
         end
      end
   endtask

   task automatic t_corners();
      apply(M - 1, M - 1, 1'b0); check("R8", int'(z), M - 2, M - 1, M - 1, 1'b0);
      apply(M - 1, 1, 1'b0);     check("R8", int'(z), 0, M - 1, 1, 1'b0);
      apply(0, M - 1, 1'b1);     check("R8", int'(z), 1, 0, M - 1, 1'b1);
      apply(0, 1, 1'b1);         check("R8", int'(z), M - 1, 0, 1, 1'b1);
      apply(M - 1, M - 1, 1'b1); check("R3", int'(z), 0, M - 1, M - 1, 1'b1);
   endtask

   // select toggles with fixed operands; same inputs after other history (R6)
   task automatic t_sel_toggle();
      int a, b;
      a = M - 51;
      b = 100;
      apply(a, b, 1'b0); check("R6", int'(z), ref_mod(a, b, 1'b0, M), a, b, 1'b0);
      apply(a, b, 1'b1); check("R6", int'(z), ref_mod(a, b, 1'b1, M), a, b, 1'b1);
      apply(3, M - 2, 1'b1);
      apply(a, b, 1'b0); check("R6", int'(z), ref_mod(a, b, 1'b0, M), a, b, 1'b0);
      apply(b, a, 1'b1); check("R6", int'(z), ref_mod(b, a, 1'b1, M), b, a, 1'b1);
      apply(b, a, 1'b0); check("R6", int'(z), ref_mod(b, a, 1'b0, M), b, a, 1'b0);
   endtask

   task automatic t_pow2();
      for (int s = 0; s < 2; s++) begin
         for (int i = 0; i < M2; i++) begin
            for (int j = 0; j < M2; j++) begin
               apply2(i, j, s[0]);
               check("R7", int'(z2), ref_mod(i, j, s[0], M2), i, j, s[0]);
            end
         end
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      x = '0; y = '0; op = 1'b0;
      x2 = '0; y2 = '0; op2 = 1'b0;
      repeat (2) @(posedge clk);
      t_idle_zero();
      t_corners();
      t_sel_toggle();
      t_pow2();
      t_add_sweep();
      t_sub_sweep();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end
endmodule